// File: doc/BRIEF.md
# Pixel Packing Output FIFO

This block sits between a pixel source and the data pins of a display panel. Pixels arrive one per valid cycle. A small serial packer groups them into byte or halfword quantities according to a shared panel-width mode. The packed values enter a 16-entry, byte-wide queue. The pin driver reads that queue from its bottom entry, one strobe per pixel clock.

The queue is a shift-down structure. Every read drops the bottom byte, and each remaining byte moves one place toward the output. The head is therefore always at a fixed location and no read pointer is needed.

Two lanes, for example the upper and lower halves of a dual panel, are built side by side. Each lane has its own packer, queue and status. The lanes share only the clock, reset, mode and flush.

Top module: `pix_pack_fifo`

## Requirements
- R1: After reset, every lane reports count 0, empty 1, full 0, overflow 0, underflow 0 and output byte 0x00.
- R2: With mode 2'b01 (8 pins; 2'b11 behaves the same), each accepted pixel writes its bits [7:0] as one entry, and bits [15:8] are ignored. Entries leave in the order they were written.
- R3: With mode 2'b00 (4 pins), each pixel supplies bits [3:0]. The count does not change on the first pixel of a pair. The second pixel writes one byte, with the first pixel in bits [3:0] and the second in bits [7:4].
- R4: With mode 2'b10 (16 pins), each pixel writes two entries: bits [7:0] go into the lower entry, which is read first, and bits [15:8] into the next entry.
- R5: A pop of a non-empty lane removes the bottom entry. In the cycle after the pop, the output shows the next older entry and the count is one lower.
- R6: The count, full and empty outputs are registers. Full is 1 exactly when the count equals 16, and empty is 1 exactly when the count is 0.
- R7: A push that lacks room is dropped and sets a sticky overflow flag. Room means one free entry, or two free entries in 16-pin mode. A dropped push leaves the count and the output byte unchanged.
- R8: A pop of an empty lane leaves the count at 0 and the output byte at its last value, and it sets a sticky underflow flag.
- R9: A push and a pop in the same cycle both take effect, and this holds even when the lane is full. In 8-pin mode such a cycle leaves the count unchanged and keeps the order.
- R10: Flush empties both lanes, discards a half-built 4-pin byte, clears both sticky flags, and takes priority over a push or pop in the same cycle.
- R11: Each lane's pushes and pops affect only that lane's data and status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Pin-width select: 00 = 4, 01 = 8, 10 = 16, 11 = 8 |
| flush | input | 1 | Synchronous clear of all lanes |
| pix_valid | input | LANES | Pixel strobe, one bit per lane |
| pix_data | input | LANES*16 | Pixel value per lane; lane k uses bits [16k+15:16k] |
| pop | input | LANES | Read strobe from the pin driver, one bit per lane |
| dout | output | LANES*8 | Bottom entry per lane |
| full | output | LANES | Lane holds 16 entries |
| empty | output | LANES | Lane holds no entry |
| count | output | LANES*5 | Valid entries per lane |
| overflow | output | LANES | Sticky flag: a push was dropped |
| underflow | output | LANES | Sticky flag: an empty lane was popped |

## Verification
The assertions assume that mode changes only while a lane holds no half-built nibble, or together with a flush. They also assume that pop and pix_valid are clean, single-cycle-per-item strobes that are held low during reset. The stimulus changes mode only between complete pixels or right after a flush, and it drives every input just after a clock edge. Overflow and underflow are produced on purpose, so the assertions about blocked pushes and empty-lane pops are exercised rather than only assumed.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    PK_NIB  = 2'b00,
    PK_BYTE = 2'b01,
    PK_HALF = 2'b10,
    PK_RSVD = 2'b11
  } pk_mode_e;

  localparam int PIX_W = 16;
endpackage

// File: rtl/pp_packer.sv
module pp_packer
  import pp_pkg::*;
#(
  parameter int ENTRY_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic [1:0]           mode,
  input  logic                 pix_valid,
  input  logic [PIX_W-1:0]     pix_data,
  input  logic                 wr_ok,
  output logic                 wr_req,
  output logic                 wr_two,
  output logic [2*ENTRY_W-1:0] wr_data
);
  localparam int NIB_W = ENTRY_W / 2;

  logic             half_q;
  logic [NIB_W-1:0] hold_q;

  always_comb begin
    wr_req  = 1'b0;
    wr_two  = 1'b0;
    wr_data = '0;
    case (pk_mode_e'(mode))
      PK_NIB: begin
        wr_req  = pix_valid & half_q;
        wr_data = {{ENTRY_W{1'b0}}, pix_data[NIB_W-1:0], hold_q};
      end
      PK_HALF: begin
        wr_req  = pix_valid;
        wr_two  = 1'b1;
        wr_data = pix_data[2*ENTRY_W-1:0];
      end
      default: begin
        wr_req  = pix_valid;
        wr_data = {{ENTRY_W{1'b0}}, pix_data[ENTRY_W-1:0]};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      half_q <= 1'b0;
      hold_q <= '0;
    end else if (pk_mode_e'(mode) != PK_NIB) begin
      half_q <= 1'b0;
    end else if (pix_valid) begin
      if (!half_q) begin
        hold_q <= pix_data[NIB_W-1:0];
        half_q <= 1'b1;
      end else if (wr_ok) begin
        half_q <= 1'b0;
      end
    end
  end

  AST_HALF_IN_NIB: assert property (@(posedge clk) disable iff (rst)
    half_q |-> $past(mode) == PK_NIB) else $error("AST_HALF_IN_NIB"); // R3
  AST_NIB_FIRST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mode == PK_NIB && !half_q) |-> !wr_req) else $error("AST_NIB_FIRST_NO_WRITE"); // R3
endmodule

// File: rtl/pp_shift_store.sv
module pp_shift_store #(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 8,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic                 wr_req,
  input  logic                 wr_two,
  input  logic [2*ENTRY_W-1:0] wr_data,
  input  logic                 pop,
  output logic                 wr_ok,
  output logic [ENTRY_W-1:0]   rd_data,
  output logic [CW-1:0]        count,
  output logic                 full,
  output logic                 empty,
  output logic                 overflow,
  output logic                 underflow
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [CW-1:0]      cnt_q;
  logic               full_q, empty_q, ovf_q, unf_q;
  logic               pop_eff;
  logic [CW:0]        need, avail, base, cnt_nxt;

  always_comb begin
    pop_eff = pop && !flush && (cnt_q != '0);
    need    = wr_two ? (CW+1)'(2) : (CW+1)'(1);
    avail   = (CW+1)'(DEPTH) - (CW+1)'(cnt_q) + (CW+1)'(pop_eff);
    base    = (CW+1)'(cnt_q) - (CW+1)'(pop_eff);
    wr_ok   = wr_req && !flush && (need <= avail);
    cnt_nxt = base + (wr_ok ? need : '0);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [ENTRY_W-1:0] above;
    if (i < DEPTH - 1) begin : g_mid
      assign above = mem[i+1];
    end else begin : g_top
      assign above = mem[i];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        mem[i] <= '0;
      end else if (wr_ok && base == (CW+1)'(i)) begin
        mem[i] <= wr_data[ENTRY_W-1:0];
      end else if (wr_ok && wr_two && base + 1'b1 == (CW+1)'(i)) begin
        mem[i] <= wr_data[2*ENTRY_W-1:ENTRY_W];
      end else if (pop_eff && (CW+1)'(i + 1) < (CW+1)'(cnt_q)) begin
        mem[i] <= above;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt[CW-1:0];
      full_q  <= (cnt_nxt == (CW+1)'(DEPTH));
      empty_q <= (cnt_nxt == '0);
      if (wr_req && !wr_ok) ovf_q <= 1'b1;
      if (pop && cnt_q == '0) unf_q <= 1'b1;
    end
  end

  assign rd_data   = mem[0];
  assign count     = cnt_q;
  assign full      = full_q;
  assign empty     = empty_q;
  assign overflow  = ovf_q;
  assign underflow = unf_q;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH)) else $error("AST_COUNT_BOUND"); // R6
  AST_FULL_FLAG: assert property (@(posedge clk) disable iff (rst)
    full_q == (cnt_q == CW'(DEPTH))) else $error("AST_FULL_FLAG"); // R6
  AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (rst)
    empty_q == (cnt_q == '0)) else $error("AST_EMPTY_FLAG"); // R6
  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (pop && !flush && cnt_q > CW'(1)) |=> rd_data == $past(mem[1])) else $error("AST_SHIFT_DOWN"); // R5
  AST_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ok && !pop && !flush) |=> ($stable(cnt_q) && $stable(rd_data)))
    else $error("AST_BLOCKED_HOLD"); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !flush) |=> ovf_q) else $error("AST_OVF_STICKY"); // R7
  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pop && cnt_q == '0 && !wr_req && !flush) |=> ($stable(rd_data) && unf_q && cnt_q == '0))
    else $error("AST_UNF_HOLD"); // R8
  AST_PAIR_COUNT: assert property (@(posedge clk) disable iff (rst)
    (pop && cnt_q != '0 && wr_req && !wr_two && !flush) |=> $stable(cnt_q))
    else $error("AST_PAIR_COUNT"); // R9
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt_q == '0 && !ovf_q && !unf_q)) else $error("AST_FLUSH_CLEARS"); // R10
endmodule

// File: rtl/pix_pack_fifo.sv
module pix_pack_fifo
  import pp_pkg::*;
#(
  parameter int LANES   = 2,
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 8,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             mode,
  input  logic                   flush,
  input  logic [LANES-1:0]       pix_valid,
  input  logic [LANES*PIX_W-1:0] pix_data,
  input  logic [LANES-1:0]       pop,
  output logic [LANES*ENTRY_W-1:0] dout,
  output logic [LANES-1:0]       full,
  output logic [LANES-1:0]       empty,
  output logic [LANES*CW-1:0]    count,
  output logic [LANES-1:0]       overflow,
  output logic [LANES-1:0]       underflow
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic                 wr_req, wr_two, wr_ok;
    logic [2*ENTRY_W-1:0] wr_data;

    pp_packer #(.ENTRY_W(ENTRY_W)) u_pack (
      .clk      (clk),
      .rst      (rst),
      .flush    (flush),
      .mode     (mode),
      .pix_valid(pix_valid[k]),
      .pix_data (pix_data[k*PIX_W +: PIX_W]),
      .wr_ok    (wr_ok),
      .wr_req   (wr_req),
      .wr_two   (wr_two),
      .wr_data  (wr_data)
    );

    pp_shift_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
      .clk      (clk),
      .rst      (rst),
      .flush    (flush),
      .wr_req   (wr_req),
      .wr_two   (wr_two),
      .wr_data  (wr_data),
      .pop      (pop[k]),
      .wr_ok    (wr_ok),
      .rd_data  (dout[k*ENTRY_W +: ENTRY_W]),
      .count    (count[k*CW +: CW]),
      .full     (full[k]),
      .empty    (empty[k]),
      .overflow (overflow[k]),
      .underflow(underflow[k])
    );
  end
endmodule

// File: tb/tb_pix_pack_fifo.sv
module tb_pix_pack_fifo;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  mode;
  logic        flush;
  logic [1:0]  pv, pp;
  logic [31:0] pd;
  logic [15:0] dout;
  logic [1:0]  full, empty, ovf, unf;
  logic [9:0]  count;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pix_pack_fifo dut (
    .clk(clk), .rst(rst), .mode(mode), .flush(flush),
    .pix_valid(pv), .pix_data(pd), .pop(pp),
    .dout(dout), .full(full), .empty(empty), .count(count),
    .overflow(ovf), .underflow(unf)
  );

  // {mode, push, pop, data, expected count, expected dout}, lane 0
  localparam logic [32:0] VEC [12] = '{
    {2'b01, 1'b1, 1'b0, 16'hFF11, 5'd1, 8'h11},  // R2 upper byte ignored
    {2'b01, 1'b1, 1'b0, 16'h0022, 5'd2, 8'h11},  // R2
    {2'b01, 1'b1, 1'b1, 16'h0033, 5'd2, 8'h22},  // R9
    {2'b01, 1'b0, 1'b1, 16'h0000, 5'd1, 8'h33},  // R5
    {2'b00, 1'b1, 1'b0, 16'h0005, 5'd1, 8'h33},  // R3 first nibble
    {2'b00, 1'b1, 1'b0, 16'h000A, 5'd2, 8'h33},  // R3 pair written
    {2'b00, 1'b0, 1'b1, 16'h0000, 5'd1, 8'hA5},  // R3 order
    {2'b10, 1'b1, 1'b0, 16'hBEEF, 5'd3, 8'hA5},  // R4
    {2'b10, 1'b0, 1'b1, 16'h0000, 5'd2, 8'hEF},  // R4 low byte first
    {2'b10, 1'b0, 1'b1, 16'h0000, 5'd1, 8'hBE},  // R4
    {2'b01, 1'b0, 1'b1, 16'h0000, 5'd0, 8'hBE},  // R5
    {2'b01, 1'b0, 1'b1, 16'h0000, 5'd0, 8'hBE}   // R8
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    pv = '0; pp = '0; flush = 1'b0;
  endtask

  task automatic push0(input logic [15:0] v);
    pv[0] = 1'b1; pd[15:0] = v;
    tick();
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; mode = 2'b01; flush = 1'b0; pv = '0; pp = '0; pd = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 empty", int'(empty), 3);
    chk("R1 full", int'(full), 0);
    chk("R1 flags", int'({ovf, unf}), 0);
    chk("R1 dout", int'(dout), 0);

    foreach (VEC[i]) begin
      mode = VEC[i][32:31];
      pv[0] = VEC[i][30];
      pp[0] = VEC[i][29];
      pd[15:0] = VEC[i][28:13];
      tick();
      chk($sformatf("R2-vector %0d count", i), int'(count[4:0]), int'(VEC[i][12:8]));
      chk($sformatf("R5-vector %0d dout", i), int'(dout[7:0]), int'(VEC[i][7:0]));
    end
    chk("R8 underflow sticky", int'(unf[0]), 1);
    chk("R6 empty after drain", int'(empty[0]), 1);

    // R10 flush clears flags
    flush = 1'b1; tick();
    chk("R10 flags cleared", int'({ovf[0], unf[0]}), 0);

    // R6 fill to full
    mode = 2'b01;
    for (int k = 0; k < 16; k++) push0(16'(k * 7 + 1));
    chk("R6 count 16", int'(count[4:0]), 16);
    chk("R6 full", int'(full[0]), 1);
    // R7 overflow
    push0(16'h0099);
    chk("R7 count held", int'(count[4:0]), 16);
    chk("R7 dout held", int'(dout[7:0]), 1);
    chk("R7 overflow set", int'(ovf[0]), 1);
    // R9 push and pop at full
    pv[0] = 1'b1; pp[0] = 1'b1; pd[15:0] = 16'h00AB; tick();
    chk("R9 count at full", int'(count[4:0]), 16);
    chk("R9 dout after pair", int'(dout[7:0]), 8);
    for (int j = 1; j <= 15; j++) begin
      pp[0] = 1'b1; tick();
      chk("R5 drain dout", int'(dout[7:0]), (j == 15) ? 8'hAB : ((j + 1) * 7 + 1));
    end
    chk("R5 drain count", int'(count[4:0]), 1);
    chk("R7 overflow sticky", int'(ovf[0]), 1);

    // R7 16-pin push with one free entry
    flush = 1'b1; tick();
    for (int k = 0; k < 15; k++) push0(16'h0040 + 16'(k));
    mode = 2'b10; push0(16'h1234);
    chk("R7 half push blocked", int'(count[4:0]), 15);
    chk("R7 half overflow", int'(ovf[0]), 1);

    // R10 flush drops half nibble and has priority over push
    flush = 1'b1; tick();
    mode = 2'b00; push0(16'h0003);
    flush = 1'b1; pv[0] = 1'b1; pd[15:0] = 16'h000C; tick();
    chk("R10 flush over push", int'(count[4:0]), 0);
    push0(16'h0007);
    push0(16'h0008);
    chk("R10 nibble restart count", int'(count[4:0]), 1);
    chk("R10 nibble restart dout", int'(dout[7:0]), 8'h87);

    // R11 lane independence
    flush = 1'b1; tick();
    mode = 2'b01;
    pv[1] = 1'b1; pd[31:16] = 16'h005A; tick();
    chk("R11 lane1 count", int'(count[9:5]), 1);
    chk("R11 lane1 dout", int'(dout[15:8]), 8'h5A);
    chk("R11 lane0 count", int'(count[4:0]), 0);
    pp[0] = 1'b1; tick();
    chk("R11 lane1 untouched", int'(count[9:5]), 1);
    chk("R11 lane underflow own", int'(unf), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule